// File: doc/BRIEF.md
# Half-Bridge Drive Sequencer with Dead-Time

This block is the digital timing core of a half-bridge converter controller. It produces four gate-control levels: the primary low-side switch, the primary high-side switch, and two secondary synchronous-rectifier drives. A counter-based PWM turns a digital duty command into primary on-pulses. Successive pulses are steered to the low-side and the high-side switch in turn. The rectifier drive that belongs to the firing switch is released before that switch turns on and is restored after it turns off. Each of those two gaps is a programmable number of clock cycles.

Switching begins under a soft-start ramp. After enable, the ramp counts up with no switching at all. Once it passes a threshold, pulses start at the configured minimum on-time and widen linearly up to the commanded value. Undervoltage, shutdown and input-detect-low each act as a fault. A fault clears the ramp and forces both primary switches off. When the fault goes away, the block restarts through soft-start, and the low-side switch fires first.

The period, duty command, duty limits and both dead-times are plain register inputs. They are taken into the block only at a period boundary.

Top module: `hb_drive_seq`

## Requirements
- R1: While `rst` is high, and on the clock edge after it is applied mid-run, `drv_lo` and `drv_hi` are 0 and `rect_a` and `rect_b` are 1. This idle state holds until switching starts.
- R2: Each period slot carries at most one primary pulse. The slots alternate: low-side, high-side, low-side. `drv_lo` and `drv_hi` are never high together. After reset or after any fault, the first pulse is on `drv_lo`.
- R3: Once soft-start has finished, consecutive primary pulse starts are `cfg_period` cycles apart. Each pulse lasts the duty command clamped into [`cfg_duty_min`, `cfg_duty_max`] cycles.
- R4: The rectifier drive that belongs to the switch goes low `cfg_dt_pre` cycles before that switch turns on. `rect_a` belongs to `drv_lo` and `rect_b` belongs to `drv_hi`. The other rectifier drive stays high through the whole slot.
- R5: The rectifier drive that belongs to the switch returns high exactly `cfg_dt_post` cycles after that switch turns off.
- R6: The pulse width is further limited to `cfg_period - cfg_dt_pre - cfg_dt_post - 1` cycles, and is never less than 1 cycle. This assumes `cfg_dt_pre + cfg_dt_post + 2 <= cfg_period`.
- R7: After enable, a ramp counts up once per clock to 2^SS_W-1. There is no switching until the ramp reaches THR = (2^SS_W-1)*3/20. The pulse latched at that point lasts `cfg_duty_min` cycles. Each later slot's limit is `cfg_duty_min + (ramp - THR) >> SS_SHIFT`, where ramp is its value when the slot is latched. This limit is capped by the clamped command.
- R8: Raising `uvlo`, `shdn` or `vin_low` forces both primaries low and both rectifier drives high at the next clock edge. It also clears the ramp. After release, switching restarts only after the R7 quiet interval.
- R9: Duty, limits, period and dead-times are captured at a slot boundary. A change during a pulse does not alter that pulse, and it takes effect in the following slot.
- R10: A primary switch is never high while its own rectifier drive is high. Both rectifier drives are never high while either primary switch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo | input | 1 | Undervoltage fault |
| shdn | input | 1 | Shutdown request |
| vin_low | input | 1 | Input-detect power-down |
| cfg_period | input | CNT_W | Cycles per pulse slot |
| cfg_duty | input | CNT_W | Duty command in cycles |
| cfg_duty_min | input | CNT_W | Lower duty clamp, soft-start starting width |
| cfg_duty_max | input | CNT_W | Upper duty clamp |
| cfg_dt_pre | input | DT_W | Rectifier-off to primary-on gap |
| cfg_dt_post | input | DT_W | Primary-off to rectifier-on gap |
| drv_lo | output | 1 | Primary low-side gate control |
| drv_hi | output | 1 | Primary high-side gate control |
| rect_a | output | 1 | Rectifier drive paired with low side |
| rect_b | output | 1 | Rectifier drive paired with high side |

## Verification
The hardest condition to reach from the ports is the very first pulses of a ramp. In that window the width is set by the soft-start limit rather than by the command. A restart additionally has to show that the ramp was truly cleared and that the low side leads, even when the fault arrived during a high-side pulse.

The stimulus handles this in several ways:
- It releases the block with a large duty command and measures the first two pulse widths against the R7 formula.
- It raises each fault input in the middle of a pulse on a chosen switch, then times the quiet interval before the next pulse.
- A row table sweeps the clamp, room-limit and zero-dead-time cases.
- A directed step changes the command in the middle of a pulse.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {LEG_LO = 1'b0, LEG_HI = 1'b1} leg_e;
  typedef enum logic [1:0] {FIRED_NONE = 2'd0, FIRED_LO = 2'd1, FIRED_HI = 2'd2} fired_e;
endpackage

// File: rtl/hb_softstart.sv
module hb_softstart #(
  parameter int CNT_W    = 10,
  parameter int SS_W     = 10,
  parameter int SS_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault,
  input  logic [CNT_W-1:0] dmin,
  input  logic [CNT_W-1:0] dmax,
  output logic             ramp_ok,
  output logic [CNT_W-1:0] on_limit
);
  localparam int THR = ((2 ** SS_W) - 1) * 3 / 20;
  localparam logic [SS_W-1:0] FULL  = '1;
  localparam logic [SS_W-1:0] THR_V = SS_W'(THR);
  localparam int SW = ((SS_W > CNT_W) ? SS_W : CNT_W) + 1;

  logic [SS_W-1:0] ramp;
  logic [SS_W-1:0] over;
  logic [SW-1:0]   grown;
  logic [SW-1:0]   cap;

  always_ff @(posedge clk) begin
    if (rst || fault) ramp <= '0;
    else if (ramp != FULL) ramp <= ramp + 1'b1;
  end

  always_comb begin
    ramp_ok = (ramp >= THR_V);
    over    = ramp - THR_V;
    grown   = SW'(dmin) + SW'(over >> SS_SHIFT);
    cap     = SW'(dmax);
    if (!ramp_ok)      on_limit = dmin;
    else if (grown > cap) on_limit = dmax;
    else               on_limit = CNT_W'(grown);
  end

  // R8
  ss_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (ramp == '0));
  // R7
  ss_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fault) |-> (ramp >= $past(ramp)));
endmodule

// File: rtl/hb_period_timer.sv
module hb_period_timer
  import hb_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DT_W  = 6,
  localparam int EW   = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] dmin,
  input  logic [CNT_W-1:0] dmax,
  input  logic [DT_W-1:0]  dt_pre,
  input  logic [DT_W-1:0]  dt_post,
  input  logic [CNT_W-1:0] on_limit,
  output logic             live,
  output leg_e             leg,
  output logic [CNT_W-1:0] cnt,
  output logic [EW-1:0]    t_on,
  output logic [EW-1:0]    t_off,
  output logic [EW-1:0]    t_sec
);
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_n;
  logic [CNT_W-1:0] d_lo, d_hi, d_ss;
  logic [EW-1:0]    need, room, d_rm, d_fin;
  logic [EW-1:0]    on_n, off_n, sec_n;
  logic             wrap;

  always_comb begin
    per_n = (cfg_period < CNT_W'(2)) ? CNT_W'(2) : cfg_period;
    d_lo  = (cfg_duty < dmin) ? dmin : cfg_duty;
    d_hi  = (d_lo > dmax) ? dmax : d_lo;
    d_ss  = (d_hi > on_limit) ? on_limit : d_hi;
    need  = EW'(dt_pre) + EW'(dt_post) + EW'(1);
    room  = (EW'(per_n) > need) ? (EW'(per_n) - need) : '0;
    d_rm  = (EW'(d_ss) > room) ? room : EW'(d_ss);
    d_fin = (d_rm == '0) ? EW'(1) : d_rm;
    on_n  = EW'(dt_pre);
    off_n = on_n + d_fin;
    sec_n = off_n + EW'(dt_post);
    wrap  = live && (cnt == per_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      live  <= 1'b0;
      cnt   <= '0;
      leg   <= LEG_LO;
      per_q <= CNT_W'(2);
      t_on  <= '0;
      t_off <= '0;
      t_sec <= '0;
    end else if (!live || wrap) begin
      live  <= 1'b1;
      cnt   <= '0;
      leg   <= (live && leg == LEG_LO) ? LEG_HI : LEG_LO;
      per_q <= per_n;
      t_on  <= on_n;
      t_off <= off_n;
      t_sec <= sec_n;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && cnt != '0) |-> ($stable(t_on) && $stable(t_off) && $stable(t_sec) && $stable(per_q)));
  // R2
  leg_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(live) && cnt == '0) |-> (leg != $past(leg)));
  // R6
  room_fit_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> ((t_sec < EW'(per_q)) && (t_off > t_on)));
endmodule

// File: rtl/hb_gate_shaper.sv
module hb_gate_shaper
  import hb_pkg::*;
#(
  parameter int CNT_W = 10,
  localparam int EW   = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault,
  input  logic             live,
  input  leg_e             leg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [EW-1:0]    t_on,
  input  logic [EW-1:0]    t_off,
  input  logic [EW-1:0]    t_sec,
  output logic             pri_lo,
  output logic             pri_hi,
  output logic             sec_a,
  output logic             sec_b
);
  logic   pri_n, rel_off_n;
  logic   lo_n, hi_n, a_n, b_n;
  fired_e last_fired;

  always_comb begin
    pri_n     = live && (EW'(cnt) >= t_on) && (EW'(cnt) < t_off);
    rel_off_n = live && (EW'(cnt) < t_sec);
    lo_n      = pri_n && (leg == LEG_LO);
    hi_n      = pri_n && (leg == LEG_HI);
    a_n       = !(rel_off_n && leg == LEG_LO);
    b_n       = !(rel_off_n && leg == LEG_HI);
  end

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      pri_lo     <= 1'b0;
      pri_hi     <= 1'b0;
      sec_a      <= 1'b1;
      sec_b      <= 1'b1;
      last_fired <= FIRED_NONE;
    end else begin
      pri_lo <= lo_n;
      pri_hi <= hi_n;
      sec_a  <= a_n;
      sec_b  <= b_n;
      if (lo_n && !pri_lo) last_fired <= FIRED_LO;
      else if (hi_n && !pri_hi) last_fired <= FIRED_HI;
    end
  end

  // R10
  lo_vs_a_chk: assert property (@(posedge clk) disable iff (rst)
    pri_lo |-> !sec_a);
  // R10
  hi_vs_b_chk: assert property (@(posedge clk) disable iff (rst)
    pri_hi |-> !sec_b);
  // R2
  pri_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pri_lo && pri_hi));
  // R2
  lo_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pri_lo) |-> ($past(last_fired) != FIRED_LO));
  // R2
  hi_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pri_hi) |-> ($past(last_fired) == FIRED_LO));
  // R8
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fault) |-> (!pri_lo && !pri_hi && sec_a && sec_b));
endmodule

// File: rtl/hb_drive_seq.sv
module hb_drive_seq
  import hb_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DT_W     = 6,
  parameter int SS_W     = 10,
  parameter int SS_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uvlo,
  input  logic             shdn,
  input  logic             vin_low,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] cfg_duty_min,
  input  logic [CNT_W-1:0] cfg_duty_max,
  input  logic [DT_W-1:0]  cfg_dt_pre,
  input  logic [DT_W-1:0]  cfg_dt_post,
  output logic             drv_lo,
  output logic             drv_hi,
  output logic             rect_a,
  output logic             rect_b
);
  localparam int EW = CNT_W + 2;

  logic             fault, run, ramp_ok, live;
  logic [CNT_W-1:0] on_limit, cnt;
  logic [EW-1:0]    t_on, t_off, t_sec;
  leg_e             leg;

  assign fault = uvlo || shdn || vin_low;
  assign run   = ramp_ok && !fault;

  hb_softstart #(.CNT_W(CNT_W), .SS_W(SS_W), .SS_SHIFT(SS_SHIFT)) u_ss (
    .clk(clk), .rst(rst), .fault(fault),
    .dmin(cfg_duty_min), .dmax(cfg_duty_max),
    .ramp_ok(ramp_ok), .on_limit(on_limit)
  );

  hb_period_timer #(.CNT_W(CNT_W), .DT_W(DT_W)) u_tmr (
    .clk(clk), .rst(rst), .run(run),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty),
    .dmin(cfg_duty_min), .dmax(cfg_duty_max),
    .dt_pre(cfg_dt_pre), .dt_post(cfg_dt_post), .on_limit(on_limit),
    .live(live), .leg(leg), .cnt(cnt),
    .t_on(t_on), .t_off(t_off), .t_sec(t_sec)
  );

  hb_gate_shaper #(.CNT_W(CNT_W)) u_shp (
    .clk(clk), .rst(rst), .fault(fault),
    .live(live), .leg(leg), .cnt(cnt),
    .t_on(t_on), .t_off(t_off), .t_sec(t_sec),
    .pri_lo(drv_lo), .pri_hi(drv_hi), .sec_a(rect_a), .sec_b(rect_b)
  );

  // R1
  idle_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (!drv_lo && !drv_hi && rect_a && rect_b));
endmodule

// File: tb/hb_drive_seq_tb.sv
module hb_drive_seq_tb;
  localparam int CNT_W = 10;
  localparam int DT_W  = 6;
  localparam int SS_W  = 10;
  localparam int SS_SHIFT = 2;
  localparam int THR   = ((2 ** SS_W) - 1) * 3 / 20;
  localparam int NV    = 7;
  // columns: period, command, min, max, pre, post, expected width, room-case flag
  localparam int V_PER [NV] = '{100, 100, 80, 40, 64, 30, 20};
  localparam int V_CMD [NV] = '{ 40,  90,  1, 39, 20, 10, 10};
  localparam int V_MIN [NV] = '{  4,   4,  6,  2,  1,  1,  1};
  localparam int V_MAX [NV] = '{ 80,  70, 60, 39, 50, 20, 15};
  localparam int V_PRE [NV] = '{  3,   2,  4,  5,  1,  0,  9};
  localparam int V_PST [NV] = '{  5,   2,  3,  6,  1,  0,  9};
  localparam int V_EXP [NV] = '{ 40,  70,  6, 28, 20, 10,  1};
  localparam int V_RM  [NV] = '{  0,   0,  0,  1,  0,  0,  1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uvlo = 1'b0, shdn = 1'b0, vin_low = 1'b0;
  logic [CNT_W-1:0] cfg_period = 10'd100, cfg_duty = 10'd60;
  logic [CNT_W-1:0] cfg_duty_min = 10'd4, cfg_duty_max = 10'd80;
  logic [DT_W-1:0]  cfg_dt_pre = 6'd3, cfg_dt_post = 6'd5;
  logic drv_lo, drv_hi, rect_a, rect_b;

  int checks = 0;
  int errors = 0;
  int ovl_err = 0;
  int alt_err = 0;
  int last_rise = 0;
  logic p_lo = 1'b0, p_hi = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_drive_seq #(.CNT_W(CNT_W), .DT_W(DT_W), .SS_W(SS_W), .SS_SHIFT(SS_SHIFT)) u_dut (
    .clk(clk), .rst(rst), .uvlo(uvlo), .shdn(shdn), .vin_low(vin_low),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty),
    .cfg_duty_min(cfg_duty_min), .cfg_duty_max(cfg_duty_max),
    .cfg_dt_pre(cfg_dt_pre), .cfg_dt_post(cfg_dt_post),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .rect_a(rect_a), .rect_b(rect_b)
  );

  // running port monitor: overlap (R10) and alternation (R2)
  always @(negedge clk) begin
    if (!rst) begin
      if ((drv_lo && drv_hi) || (drv_lo && rect_a) || (drv_hi && rect_b)) ovl_err++;
      if (drv_lo && !p_lo) begin
        if (last_rise == 1) alt_err++;
        last_rise = 1;
      end
      if (drv_hi && !p_hi) begin
        if (last_rise != 1) alt_err++;
        last_rise = 2;
      end
    end
    if (rst || uvlo || shdn || vin_low) last_rise = 0;
    p_lo = drv_lo;
    p_hi = drv_hi;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges until a primary turns on; reports which one
  task automatic wait_first(output int dly, output int was_lo);
    dly = -1; was_lo = 0;
    for (int i = 1; i < 5000; i++) begin
      @(negedge clk);
      if (drv_lo || drv_hi) begin
        dly = i; was_lo = drv_lo ? 1 : 0;
        break;
      end
    end
  endtask

  // width of a pulse already high (counts the current sample)
  task automatic width_now(input bit hi, output int w);
    w = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((hi ? drv_hi : drv_lo) == 1'b0) break;
      w++;
    end
  endtask

  task automatic next_width(input bit hi, output int w);
    w = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ((hi ? drv_hi : drv_lo) == 1'b1) begin
        width_now(hi, w);
        break;
      end
    end
  endtask

  task automatic measure(output int pre, output int wid, output int post,
                         output int gap, output int b_dropped);
    int t0, t1, t2, t3, t4;
    bit g0, g1, g2, g3, g4;
    logic pa, pl, ph;
    g0 = 0; g1 = 0; g2 = 0; g3 = 0; g4 = 0;
    t0 = 0; t1 = 0; t2 = 0; t3 = 0; t4 = 0;
    b_dropped = 0;
    pa = rect_a; pl = drv_lo; ph = drv_hi;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (!g0 && pa && !rect_a) begin g0 = 1; t0 = n; end
      if (g0 && !g3 && !rect_b) b_dropped = 1;
      if (g0 && !g1 && !pl && drv_lo) begin g1 = 1; t1 = n; end
      if (g1 && !g2 && pl && !drv_lo) begin g2 = 1; t2 = n; end
      if (g2 && !g3 && !pa && rect_a) begin g3 = 1; t3 = n; end
      if (g1 && !g4 && !ph && drv_hi) begin g4 = 1; t4 = n; end
      pa = rect_a; pl = drv_lo; ph = drv_hi;
      if (g3 && g4) break;
    end
    pre  = (g1) ? t1 - t0 : -1;
    wid  = (g2) ? t2 - t1 : -1;
    post = (g3) ? t3 - t2 : -1;
    gap  = (g4) ? t4 - t1 : -1;
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dly, was_lo, w, pre, wid, post, gap, bd;
    cycles(5);
    // R1: idle while reset
    check("R1 reset drv_lo", int'(drv_lo), 0);
    check("R1 reset drv_hi", int'(drv_hi), 0);
    check("R1 reset rects", int'(rect_a && rect_b), 1);

    // R7: soft-start quiet interval and first widths
    rst = 1'b0;
    wait_first(dly, was_lo);
    check("R7 quiet interval lower bound", int'(dly >= THR), 1);
    check("R7 quiet interval upper bound", int'(dly <= THR + 3 + 4), 1);
    check("R2 first pulse on low side", was_lo, 1);
    width_now(1'b0, w);
    check("R7 first width is min", w, 4);
    next_width(1'b1, w);
    check("R7 second width follows ramp", w, 4 + (100 >> SS_SHIFT));
    cycles(1200);

    // R3/R4/R5/R6: table of settings after soft-start
    for (int v = 0; v < NV; v++) begin
      cfg_period   = CNT_W'(V_PER[v]);
      cfg_duty     = CNT_W'(V_CMD[v]);
      cfg_duty_min = CNT_W'(V_MIN[v]);
      cfg_duty_max = CNT_W'(V_MAX[v]);
      cfg_dt_pre   = DT_W'(V_PRE[v]);
      cfg_dt_post  = DT_W'(V_PST[v]);
      cycles(3 * V_PER[v]);
      measure(pre, wid, post, gap, bd);
      check("R4 pre dead-time", pre, V_PRE[v]);
      if (V_RM[v] != 0) check("R6 room-limited width", wid, V_EXP[v]);
      else              check("R3 clamped width", wid, V_EXP[v]);
      check("R5 post dead-time", post, V_PST[v]);
      check("R3 slot spacing", gap, V_PER[v]);
      check("R4 other rectifier held", bd, 0);
    end

    // R9: change command during a low pulse
    cfg_period = 10'd100; cfg_duty = 10'd40; cfg_duty_min = 10'd4;
    cfg_duty_max = 10'd80; cfg_dt_pre = 6'd3; cfg_dt_post = 6'd5;
    cycles(300);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drv_lo) break;
    end
    cfg_duty = 10'd20;
    width_now(1'b0, w);
    check("R9 pulse in flight keeps old width", w, 40);
    next_width(1'b1, w);
    check("R9 next slot uses new width", w, 20);

    // R8: shutdown during a low pulse
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drv_lo) break;
    end
    shdn = 1'b1;
    @(negedge clk);
    check("R8 shutdown forces primaries off", int'(drv_lo || drv_hi), 0);
    check("R8 shutdown rects on", int'(rect_a && rect_b), 1);
    cycles(5);
    shdn = 1'b0;
    wait_first(dly, was_lo);
    check("R8 ramp restarted after shutdown", int'(dly >= THR), 1);
    check("R2 low side first after shutdown", was_lo, 1);

    // R8: undervoltage and input-detect during a high pulse
    cycles(400);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drv_hi) break;
    end
    vin_low = 1'b1;
    @(negedge clk);
    check("R8 input-detect forces high side off", int'(drv_hi), 0);
    cycles(3);
    vin_low = 1'b0;
    wait_first(dly, was_lo);
    check("R2 low side first after high-side fault", was_lo, 1);
    check("R8 quiet after input-detect", int'(dly >= THR), 1);
    cycles(400);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drv_hi) break;
    end
    uvlo = 1'b1;
    @(negedge clk);
    check("R8 undervoltage forces off", int'(drv_lo || drv_hi || !rect_a || !rect_b), 0);
    uvlo = 1'b0;
    cycles(400);

    // R1: reset applied mid-run
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (drv_lo) break;
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset idle", int'(!drv_lo && !drv_hi && rect_a && rect_b), 1);
    cycles(3);

    check("R10 no primary/rectifier overlap", ovl_err, 0);
    check("R2 alternation monitor", alt_err, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule